// File: doc/BRIEF.md
# Data-Driven Wavefront Matrix Multiplier

The block multiplies two square matrices of signed fixed-point numbers, C = A·B, on a grid of DIM×DIM multiply-accumulate elements (DIM = 3 by default). Columns of A arrive one per beat on a valid/ready stream and enter the grid at the left edge, one value per row. Rows of B arrive on a second valid/ready stream and enter at the top edge, one value per column. Each element accumulates products and hands its A operand to the element on its right and its B operand to the element below. Nothing in the grid follows a global schedule. An element fires when both of its incoming links hold data and both of its outgoing links are empty. A stall on either input stream therefore spreads through the grid as a wave, and the diagonal skew between rows and columns comes from the hop count and needs no padding slots.

Every link is a one-entry register with a valid flag. When all elements have taken DIM products, a done flag rises. The nine results then leave on a valid/ready result stream in row-major order, each with its index. A synchronous clear empties all links and zeroes every accumulator and counter before the next product.

Top module: `wf_matmul`

## Requirements
- R1: Result element (i,j) equals the sum over k of a[i][k]·b[k][j], formed from 16-bit two's-complement operands in a 36-bit signed accumulator that starts at zero.
- R2: Beat k of the A stream carries column k of A, with a[i][k] in a_data bits [16i+15:16i]. Beat k of the B stream carries row k of B, with b[k][j] in b_data bits [16j+15:16j]. Each stream accepts exactly DIM beats per product. Its ready stays low after that until a clear.
- R3: An element computes only on operands that have reached it through its upstream links. Element (i,j) never holds more products than its left or upper neighbour. A-beats with no B-beats stall after the first beat fills the left edge, and done stays low.
- R4: The result is the same whatever the pattern of stalls on the A stream, the B stream and the result stream.
- R5: Results leave in row-major order. r_idx = i·DIM + j and r_data = c[i][j]. While r_valid is high and r_ready is low, r_valid, r_data and r_idx hold.
- R6: done rises once every element has accumulated DIM products, and r_valid is high only while done is high.
- R7: A one-cycle clear drops done and r_valid, reopens both input streams, and removes all partial sums, so the next product is uncontaminated.
- R8: After reset, a_ready and b_ready are high, and r_valid and done are low.
- R9: Full-scale operands do not overflow. With every operand at -32768, each result is 3221225472.
- R10: After the last result (index DIM·DIM-1) is accepted, r_valid stays low until a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear before a new product |
| a_valid | input | 1 | A column beat offered |
| a_ready | output | 1 | A column beat accepted |
| a_data | input | DIM·16 | One column of A, row i in slice i |
| b_valid | input | 1 | B row beat offered |
| b_ready | output | 1 | B row beat accepted |
| b_data | input | DIM·16 | One row of B, column j in slice j |
| r_valid | output | 1 | Result element offered |
| r_ready | input | 1 | Result element taken |
| r_data | output | 36 | Signed result element |
| r_idx | output | 4 | Row-major index of r_data |
| done | output | 1 | All elements hold DIM products |

## Verification
A link whose valid flag gets stuck or clears early either stalls the grid or pairs operands from different k. The first shows as done never rising, which the bench catches with its loop bound. The second gives wrong values on the result stream in the same product. An element counter that misses a step delays or blocks done, while one that adds an extra step lets an unmatched operand into a sum. Errors in the read-out register show at once as an out-of-order r_idx, or as a result that changes or repeats while it is back-pressured. Random stalls on all three streams make these faults show up within one product.

// File: rtl/wf_pkg.sv
package wf_pkg;
  localparam int unsigned WF_DIM = 3;   // grid edge length
  localparam int unsigned WF_DW  = 16;  // operand width
  localparam int unsigned WF_AW  = 36;  // accumulator width
endpackage

// File: rtl/wf_link.sv
// One-entry hand-off register between neighbouring elements.
module wf_link #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic          take,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q,
  output logic          vld
);
  logic vld_d;

  always_comb begin
    vld_d = vld;
    if (take) vld_d = 1'b0;
    if (load) vld_d = 1'b1;
    if (clr)  vld_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld <= 1'b0;
    else        vld <= vld_d;
  end

  always_ff @(posedge clk) begin
    if (load) q <= d;
  end
endmodule

// File: rtl/wf_pe.sv
// Multiply-accumulate element; fires when both operands are present
// and both outgoing links can take them.
module wf_pe #(
  parameter int unsigned DW    = 16,
  parameter int unsigned AW    = 36,
  parameter int unsigned STEPS = 3,
  parameter int unsigned CW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  input  logic          a_v,
  input  logic          b_v,
  input  logic          a_free,
  input  logic          b_free,
  output logic          fire,
  output logic [AW-1:0] acc,
  output logic [CW-1:0] cnt
);
  localparam int unsigned PW = 2 * DW;

  logic [PW-1:0] a_x, b_x, prod;
  logic [AW-1:0] acc_d;
  logic [CW-1:0] cnt_d;

  assign a_x  = {{DW{a_in[DW-1]}}, a_in};
  assign b_x  = {{DW{b_in[DW-1]}}, b_in};
  assign prod = a_x * b_x;

  always_comb begin
    fire  = a_v & b_v & a_free & b_free & (cnt < CW'(STEPS)) & ~clr;
    acc_d = acc;
    cnt_d = cnt;
    if (fire) begin
      acc_d = acc + {{(AW-PW){prod[PW-1]}}, prod};
      cnt_d = cnt + 1'b1;
    end
    if (clr) begin
      acc_d = '0;
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      cnt <= '0;
    end else begin
      acc <= acc_d;
      cnt <= cnt_d;
    end
  end
endmodule

// File: rtl/wf_drain.sv
// Row-major read-out of the finished result grid.
module wf_drain #(
  parameter int unsigned N  = 9,
  parameter int unsigned AW = 36,
  parameter int unsigned IW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            done,
  input  logic            r_ready,
  input  logic [N*AW-1:0] acc_flat,
  output logic            r_valid,
  output logic [AW-1:0]   r_data,
  output logic [IW-1:0]   r_idx
);
  logic          drained, drained_d;
  logic [IW-1:0] idx_d;

  assign r_valid = done & ~drained;
  assign r_data  = acc_flat[int'(r_idx)*AW +: AW];

  always_comb begin
    idx_d     = r_idx;
    drained_d = drained;
    if (r_valid && r_ready) begin
      if (r_idx == IW'(N-1)) drained_d = 1'b1;
      else                   idx_d     = r_idx + 1'b1;
    end
    if (clr) begin
      idx_d     = '0;
      drained_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r_idx   <= '0;
      drained <= 1'b0;
    end else begin
      r_idx   <= idx_d;
      drained <= drained_d;
    end
  end
endmodule

// File: rtl/wf_matmul.sv
module wf_matmul #(
  parameter int unsigned DIM = wf_pkg::WF_DIM,
  parameter int unsigned DW  = wf_pkg::WF_DW,
  parameter int unsigned AW  = wf_pkg::WF_AW,
  localparam int unsigned CW = $clog2(DIM + 1),
  localparam int unsigned NE = DIM * DIM,
  localparam int unsigned IW = $clog2(NE)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            a_valid,
  output logic            a_ready,
  input  logic [DIM*DW-1:0] a_data,
  input  logic            b_valid,
  output logic            b_ready,
  input  logic [DIM*DW-1:0] b_data,
  output logic            r_valid,
  input  logic            r_ready,
  output logic [AW-1:0]   r_data,
  output logic [IW-1:0]   r_idx,
  output logic            done
);
  // link into element (i,j): data, valid; outgoing-space flags; fire
  logic [DW-1:0] a_ld   [DIM][DIM];
  logic [DW-1:0] b_ld   [DIM][DIM];
  logic          a_lv   [DIM][DIM];
  logic          b_lv   [DIM][DIM];
  logic          a_free [DIM][DIM];
  logic          b_free [DIM][DIM];
  logic          fire   [DIM][DIM];

  logic [NE*AW-1:0] acc_flat;
  logic [NE*CW-1:0] cnt_flat;

  logic [CW-1:0] a_beats, b_beats, a_beats_d, b_beats_d;
  logic          a_edge_empty, b_edge_empty, a_acc, b_acc;

  // stream acceptance at the edges
  always_comb begin
    a_edge_empty = 1'b1;
    b_edge_empty = 1'b1;
    for (int k = 0; k < DIM; k++) begin
      a_edge_empty &= ~a_lv[k][0];
      b_edge_empty &= ~b_lv[0][k];
    end
    a_ready   = ~clr & (a_beats < CW'(DIM)) & a_edge_empty;
    b_ready   = ~clr & (b_beats < CW'(DIM)) & b_edge_empty;
    a_acc     = a_valid & a_ready;
    b_acc     = b_valid & b_ready;
    a_beats_d = clr ? '0 : a_beats + CW'(a_acc);
    b_beats_d = clr ? '0 : b_beats + CW'(b_acc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_beats <= '0;
      b_beats <= '0;
    end else begin
      a_beats <= a_beats_d;
      b_beats <= b_beats_d;
    end
  end

  // grid completion
  always_comb begin
    done = 1'b1;
    for (int e = 0; e < NE; e++)
      done &= (cnt_flat[e*CW +: CW] == CW'(DIM));
  end

  genvar gi, gj;
  generate
    for (gi = 0; gi < DIM; gi++) begin : g_edge
      wf_link #(.DW(DW)) u_a_edge (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load(a_acc), .take(fire[gi][0]),
        .d(a_data[gi*DW +: DW]), .q(a_ld[gi][0]), .vld(a_lv[gi][0]));
      wf_link #(.DW(DW)) u_b_edge (
        .clk(clk), .rst_n(rst_n), .clr(clr), .load(b_acc), .take(fire[0][gi]),
        .d(b_data[gi*DW +: DW]), .q(b_ld[0][gi]), .vld(b_lv[0][gi]));
    end

    for (gi = 0; gi < DIM; gi++) begin : g_row
      for (gj = 0; gj < DIM; gj++) begin : g_col
        if (gj == DIM - 1) begin : g_a_sink
          assign a_free[gi][gj] = 1'b1;
        end else begin : g_a_fwd
          assign a_free[gi][gj] = ~a_lv[gi][gj+1];
          wf_link #(.DW(DW)) u_a_lnk (
            .clk(clk), .rst_n(rst_n), .clr(clr),
            .load(fire[gi][gj]), .take(fire[gi][gj+1]),
            .d(a_ld[gi][gj]), .q(a_ld[gi][gj+1]), .vld(a_lv[gi][gj+1]));
        end

        if (gi == DIM - 1) begin : g_b_sink
          assign b_free[gi][gj] = 1'b1;
        end else begin : g_b_fwd
          assign b_free[gi][gj] = ~b_lv[gi+1][gj];
          wf_link #(.DW(DW)) u_b_lnk (
            .clk(clk), .rst_n(rst_n), .clr(clr),
            .load(fire[gi][gj]), .take(fire[gi+1][gj]),
            .d(b_ld[gi][gj]), .q(b_ld[gi+1][gj]), .vld(b_lv[gi+1][gj]));
        end

        wf_pe #(.DW(DW), .AW(AW), .STEPS(DIM), .CW(CW)) u_pe (
          .clk(clk), .rst_n(rst_n), .clr(clr),
          .a_in(a_ld[gi][gj]), .b_in(b_ld[gi][gj]),
          .a_v(a_lv[gi][gj]), .b_v(b_lv[gi][gj]),
          .a_free(a_free[gi][gj]), .b_free(b_free[gi][gj]),
          .fire(fire[gi][gj]),
          .acc(acc_flat[(gi*DIM+gj)*AW +: AW]),
          .cnt(cnt_flat[(gi*DIM+gj)*CW +: CW]));
      end
    end
  endgenerate

  wf_drain #(.N(NE), .AW(AW), .IW(IW)) u_drain (
    .clk(clk), .rst_n(rst_n), .clr(clr), .done(done), .r_ready(r_ready),
    .acc_flat(acc_flat), .r_valid(r_valid), .r_data(r_data), .r_idx(r_idx));
endmodule

// File: rtl/wf_matmul_chk.sv
module wf_matmul_chk #(
  parameter int unsigned DIM = 3,
  parameter int unsigned AW  = 36,
  parameter int unsigned CW  = 2,
  parameter int unsigned IW  = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  clr,
  input logic                  a_ready,
  input logic                  b_ready,
  input logic                  r_valid,
  input logic                  r_ready,
  input logic [AW-1:0]         r_data,
  input logic [IW-1:0]         r_idx,
  input logic                  done,
  input logic [DIM*DIM*CW-1:0] cnt_flat
);
  localparam int unsigned LAST = DIM * DIM - 1;

  // R5: back-pressured result holds
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n || clr)
    r_valid && !r_ready |=> r_valid && $stable(r_data) && $stable(r_idx));

  // R6: results only after completion
  a_r6_valid_needs_done: assert property (@(posedge clk) disable iff (!rst_n)
    r_valid |-> done);

  // R2: no extra beats once complete
  a_r2_no_extra_beats: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !a_ready && !b_ready);

  // R7: clear drops completion and output
  a_r7_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !done && !r_valid);

  // R10: quiet after last element
  a_r10_quiet_after_last: assert property (@(posedge clk) disable iff (!rst_n || clr)
    r_valid && r_ready && r_idx == IW'(LAST) |=> !r_valid);

  // R3: an element never runs ahead of its upstream neighbours
  genvar gi, gj;
  generate
    for (gi = 0; gi < DIM; gi++) begin : g_r
      for (gj = 0; gj < DIM; gj++) begin : g_c
        if (gj > 0) begin : g_left
          a_r3_behind_left: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_flat[(gi*DIM+gj)*CW +: CW] <= cnt_flat[(gi*DIM+gj-1)*CW +: CW]);
        end
        if (gi > 0) begin : g_up
          a_r3_behind_up: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_flat[(gi*DIM+gj)*CW +: CW] <= cnt_flat[((gi-1)*DIM+gj)*CW +: CW]);
        end
      end
    end
  endgenerate
endmodule

bind wf_matmul wf_matmul_chk #(.DIM(DIM), .AW(AW), .CW(CW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr(clr), .a_ready(a_ready), .b_ready(b_ready),
  .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_idx(r_idx),
  .done(done), .cnt_flat(cnt_flat));

// File: tb/tb_wf_matmul.sv
module tb_wf_matmul;
  localparam int P  = 10;
  localparam int NV = 4;

  // stimulus vectors: A and B row-major, stall mode; expected C computed below
  localparam logic signed [15:0] TBL_A [NV][9] = '{
    '{1, 2, 3, 4, 5, 6, 7, 8, 9},
    '{-5, 12, 0, 7, -3, 100, -1000, 2, 9},
    '{-32768, -32768, -32768, -32768, -32768, -32768, -32768, -32768, -32768},
    '{32767, -32768, 1, -1, 32767, 0, 250, -250, 32767}};
  localparam logic signed [15:0] TBL_B [NV][9] = '{
    '{1, 0, 2, 0, 1, -1, 3, -2, 1},
    '{4, -8, 15, 16, 23, -42, -7, 0, 311},
    '{-32768, -32768, -32768, -32768, -32768, -32768, -32768, -32768, -32768},
    '{-32768, 32767, 3, 32767, -32768, -3, 1, 2, -32768}};
  localparam int TBL_MODE [NV] = '{0, 1, 2, 1};

  logic        clk = 1'b0;
  logic        rst_n, clr;
  logic        a_valid, b_valid, r_ready;
  logic        a_ready, b_ready, r_valid, done;
  logic [47:0] a_data, b_data;
  logic [35:0] r_data;
  logic [3:0]  r_idx;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  logic signed [15:0] cur_a [9];
  logic signed [15:0] cur_b [9];

  always #(P/2) clk = ~clk;

  wf_matmul dut (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
    .r_valid(r_valid), .r_ready(r_ready), .r_data(r_data), .r_idx(r_idx),
    .done(done));

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint expc(input int idx);
    longint s = 0;
    for (int k = 0; k < 3; k++)
      s += longint'(cur_a[(idx/3)*3+k]) * longint'(cur_b[k*3+(idx%3)]);
    return s;
  endfunction

  function automatic logic [47:0] a_beat(input int k);
    logic [47:0] v;
    for (int i = 0; i < 3; i++) v[i*16 +: 16] = cur_a[i*3+k];
    return v;
  endfunction

  function automatic logic [47:0] b_beat(input int k);
    logic [47:0] v;
    for (int j = 0; j < 3; j++) v[j*16 +: 16] = cur_b[k*3+j];
    return v;
  endfunction

  task automatic load_entry(input int v);
    for (int e = 0; e < 9; e++) begin
      cur_a[e] = TBL_A[v][e];
      cur_b[e] = TBL_B[v][e];
    end
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic run_op(input bit do_clr, input int mode, input string tag);
    int ka = 0, kb = 0, nr = 0, cyc = 0;
    bit sa, sb, sr;
    if (do_clr) pulse_clr();
    while (nr < 9 && cyc < 3000) begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      sa = (mode == 1) ? lfsr[0] : (mode == 2) ? (lfsr[0] | lfsr[3]) : 1'b0;
      sb = (mode == 1) ? lfsr[1] : (mode == 2) ? (lfsr[1] | lfsr[4]) : 1'b0;
      sr = (mode == 1) ? lfsr[2] : (mode == 2) ? (lfsr[2] | lfsr[5]) : 1'b0;
      a_valid = (ka < 3) && !sa;
      b_valid = (kb < 3) && !sb;
      if (ka < 3) a_data = a_beat(ka);
      if (kb < 3) b_data = b_beat(kb);
      r_ready = !sr;
      #(P/2 - 1);
      if (a_valid && a_ready) ka++;
      if (b_valid && b_ready) kb++;
      if (r_valid && r_ready) begin
        check(r_idx == 4'(nr), {"R5 index ", tag}, longint'(r_idx), longint'(nr));
        check(longint'($signed(r_data)) == expc(nr), {"R1 value ", tag},
              longint'($signed(r_data)), expc(nr));
        nr++;
      end
      cyc++;
    end
    check(nr == 9, {"R6 all results ", tag}, longint'(nr), 9);
    @(negedge clk);
    a_valid = 1'b0; b_valid = 1'b0; r_ready = 1'b1;
    #(P/2 - 1);
    check(r_valid == 1'b0, {"R10 quiet ", tag}, longint'(r_valid), 0);
    check(a_ready == 1'b0 && b_ready == 1'b0, {"R2 beats closed ", tag},
          longint'({a_ready, b_ready}), 0);
    check(done == 1'b1, {"R6 done held ", tag}, longint'(done), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int ka;
    rst_n = 1'b0; clr = 1'b0; a_valid = 1'b0; b_valid = 1'b0; r_ready = 1'b0;
    a_data = '0; b_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #(P/2 - 1);
    // R8 reset state
    check(a_ready == 1'b1, "R8 a_ready", longint'(a_ready), 1);
    check(b_ready == 1'b1, "R8 b_ready", longint'(b_ready), 1);
    check(r_valid == 1'b0, "R8 r_valid", longint'(r_valid), 0);
    check(done == 1'b0, "R8 done", longint'(done), 0);

    // vector table: plain (R1), stalled (R4), full scale (R9)
    for (int v = 0; v < NV; v++) begin
      load_entry(v);
      run_op(1'b1, TBL_MODE[v], (v == 2) ? "R9" : (TBL_MODE[v] != 0) ? "R4" : "R1");
    end

    // R3: A alone cannot advance past the left edge
    load_entry(1);
    pulse_clr();
    ka = 0;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      a_valid = 1'b1; a_data = a_beat(ka); b_valid = 1'b0;
      #(P/2 - 1);
      if (a_valid && a_ready) ka++;
    end
    check(ka == 1, "R3 A stalls without B", longint'(ka), 1);
    check(done == 1'b0, "R3 done low", longint'(done), 0);
    @(negedge clk);
    a_valid = 1'b0; b_valid = 1'b1; b_data = b_beat(0);
    #(P/2 - 1);
    check(b_ready == 1'b1, "R3 B edge open", longint'(b_ready), 1);
    @(negedge clk); b_valid = 1'b0;
    repeat (4) @(negedge clk);

    // R7: clear mid-product, then a fresh product with no further clear
    clr = 1'b1;
    @(negedge clk); clr = 1'b0;
    #(P/2 - 1);
    check(a_ready == 1'b1 && b_ready == 1'b1, "R7 streams reopen",
          longint'({a_ready, b_ready}), 3);
    check(done == 1'b0 && r_valid == 1'b0, "R7 done/r_valid low",
          longint'({done, r_valid}), 0);
    load_entry(0);
    run_op(1'b0, 1, "R7");

    // R7: clear after completion drops the output
    pulse_clr();
    #(P/2 - 1);
    check(done == 1'b0 && r_valid == 1'b0, "R7 clear after done",
          longint'({done, r_valid}), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule